// File: doc/BRIEF.md
# Lock-step Vector Issue Controller with Lane Masking

This block is a single instruction sequencer that feeds a row of identical execution lanes which all run in lock-step. Each lane has its own small register file, its own local data memory and a one-bit predicate. The sequencer reads a program from its own instruction memory. It sends every lane-bound instruction to all lanes in the same clock, together with an enable mask. A lane executes the word only when its mask bit is set.

Counted loops run entirely inside the sequencer, so the loop counter and its test never reach the lanes. A data-dependent conditional is handled in three steps. The lanes compare values and set their predicates. The sequencer gathers those predicates and runs the taken path with one set of lanes enabled, then the other path with the rest. At the join point it restores the mask that was in force before the branch. Nesting is handled by a small mask stack. A host loads the program and the lane memories through plain write ports, pulses `start`, and waits for `done`.

The controller is a four-state machine:
- **IDLE**: the state after reset.
- **RUN**: one program word is handled per clock.
- **SETTLE**: a one-clock wait entered from RUN on a branch word, so that the predicates of the latest compare can land; it always returns to RUN.
- **DONE**: entered from RUN on a halt word.

A `start` pulse moves IDLE or DONE to RUN. In DONE, `start` is the only way out.

Top module: `simd_array_top`

## Requirements
- R1: After reset `done` and `bus_valid` are low, and they stay low until `start` is pulsed.
- R2: Every lane-bound word (opcodes 0 to 8) reaches `bus_instr` exactly once, in program order, with the mask in force at that point. A lane with a clear mask bit leaves its registers, predicate and memory unchanged.
- R3: `LOOP n` (opcode 9, count in bits 5:0) and `ENDL t` (opcode 10, target in bits 5:0) never appear on the bus. The body between them is issued exactly n times (n at least 1).
- R4: `HALT` (opcode 15) stops issue. No broadcast follows it, and `done` stays high until the next `start`.
- R5: `IFP` (opcode 11, else target in bits 11:6, join address in bits 5:0) runs the first path with mask AND predicate. After `ELS` (opcode 12) it runs the second path with mask AND NOT predicate. `JOIN` (opcode 13) restores the mask from before the branch.
- R6: A path whose mask would be all zero is skipped. No broadcast has an empty mask. An empty first path jumps to the else target, and an empty second path jumps to the join address.
- R7: `LD rd,[ra]` (opcode 4) loads a lane register from that lane's own memory at the address held in `ra`. `ST [ra],rb` (opcode 5) stores `rb` there. Both run in every enabled lane at the same time.
- R8: Consecutive lane-bound words are broadcast on consecutive clocks, one per clock.
- R9: Word layout: opcode in bits 15:12, rd in 11:9, ra in 8:6, rb in 5:3, and a 6-bit immediate in 5:0. `LDI` is opcode 1, `ADD` 2, `SUB` 3, `SLT` 6 (predicate is ra < rb, unsigned), and `LID` 8 (writes the lane index). Branches nest correctly up to the stack depth of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| prog_we | input | 1 | instruction memory write strobe |
| prog_addr | input | 6 | instruction memory write address |
| prog_data | input | 16 | instruction word to write |
| start | input | 1 | begin execution at address 0 with all lanes enabled |
| done | output | 1 | halt word reached |
| host_we | input | 1 | lane memory write strobe |
| host_lane | input | 3 | lane selected for host access |
| host_addr | input | 5 | lane memory address for host access |
| host_wdata | input | 16 | lane memory write data |
| host_rdata | output | 16 | lane memory read data, combinational |
| bus_valid | output | 1 | a word is broadcast to the lanes this clock |
| bus_instr | output | 16 | broadcast instruction word |
| bus_mask | output | 8 | lane enable mask for the broadcast word |

## Verification
The assertions take for granted the following about the input:
- Programs nest branches no deeper than four levels.
- Every `JOIN` pairs with an earlier `IFP`.
- Loop counts are at least one.
- The host leaves the program and lane memories alone while the machine is in RUN.

The stimulus keeps within these limits. It uses two fixed programs: a counted element-wise maximum and a two-level nested classification by lane index. It touches memories only before `start` or after `done`.

The data for the maximum is chosen so that different loop iterations give:
- an all-taken branch,
- an all-not-taken branch,
- mixed branches.

This drives both skip rules as well as the normal split.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;
    localparam int INSTR_W = 16;
    localparam int PC_W    = 6;
    localparam int REG_CNT = 8;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_LDI  = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_LD   = 4'd4,
        OP_ST   = 4'd5,
        OP_SLT  = 4'd6,
        OP_LID  = 4'd8,
        OP_LOOP = 4'd9,
        OP_ENDL = 4'd10,
        OP_IFP  = 4'd11,
        OP_ELS  = 4'd12,
        OP_JOIN = 4'd13,
        OP_HALT = 4'd15
    } opcode_e;

    typedef struct packed {
        logic [3:0] op;
        logic [2:0] rd;
        logic [2:0] ra;
        logic [2:0] rb;
        logic [2:0] lo;
    } instr_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RUN    = 2'd1,
        S_SETTLE = 2'd2,
        S_DONE   = 2'd3
    } seq_state_e;

    function automatic logic is_lane_op(input logic [3:0] op);
        return (op < 4'd9);
    endfunction
endpackage

// File: rtl/simd_lane.sv
`timescale 1ns/1ps
module simd_lane
    import simd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MEM_DEPTH = 32,
    parameter int LANE_IDX  = 0,
    localparam int MEM_AW   = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [15:0]       bus_instr,
    input  logic              enable,
    input  logic              host_we,
    input  logic [MEM_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              pred
);
    instr_t            ins;
    logic              exec;
    logic [DATA_W-1:0] rf  [REG_CNT];
    logic [DATA_W-1:0] mem [MEM_DEPTH];
    logic [MEM_AW-1:0] ea;

    assign ins        = instr_t'(bus_instr);
    assign exec       = bus_valid && enable;
    assign ea         = rf[ins.ra][MEM_AW-1:0];
    assign host_rdata = mem[host_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_CNT; i++) rf[i] <= '0;
            pred <= 1'b0;
        end else if (exec) begin
            case (ins.op)
                OP_LDI: rf[ins.rd] <= {{(DATA_W-6){1'b0}}, ins.rb, ins.lo};
                OP_ADD: rf[ins.rd] <= rf[ins.ra] + rf[ins.rb];
                OP_SUB: rf[ins.rd] <= rf[ins.ra] - rf[ins.rb];
                OP_LD:  rf[ins.rd] <= mem[ea];
                OP_SLT: pred       <= (rf[ins.ra] < rf[ins.rb]);
                OP_LID: rf[ins.rd] <= DATA_W'(LANE_IDX);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (host_we)
            mem[host_addr] <= host_wdata;
        else if (exec && ins.op == OP_ST)
            mem[ea] <= rf[ins.rb];
    end

    // R2: a lane left out of a broadcast keeps its predicate
    a_r2_masked_pred_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable(pred));
endmodule

// File: rtl/simd_mask_stack.sv
`timescale 1ns/1ps
module simd_mask_stack #(
    parameter int N_LANES = 8,
    parameter int DEPTH   = 4,
    parameter int PC_W    = 6,
    localparam int SP_W   = $clog2(DEPTH + 1),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    input  logic [N_LANES-1:0] push_saved,
    input  logic [N_LANES-1:0] push_else,
    input  logic [PC_W-1:0]    push_join,
    output logic [N_LANES-1:0] top_saved,
    output logic [N_LANES-1:0] top_else,
    output logic [PC_W-1:0]    top_join
);
    logic [N_LANES-1:0] saved_q [DEPTH];
    logic [N_LANES-1:0] else_q  [DEPTH];
    logic [PC_W-1:0]    join_q  [DEPTH];
    logic [SP_W-1:0]    sp;
    logic [IDX_W-1:0]   wr_idx, top_idx;

    assign wr_idx    = sp[IDX_W-1:0];
    assign top_idx   = IDX_W'(sp - 1'b1);
    assign top_saved = saved_q[top_idx];
    assign top_else  = else_q[top_idx];
    assign top_join  = join_q[top_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                saved_q[i] <= '0;
                else_q[i]  <= '0;
                join_q[i]  <= '0;
            end
        end else if (push) begin
            saved_q[wr_idx] <= push_saved;
            else_q[wr_idx]  <= push_else;
            join_q[wr_idx]  <= push_join;
            sp              <= sp + 1'b1;
        end else if (pop) begin
            sp <= sp - 1'b1;
        end
    end

    // R9: nesting stays within the stack
    a_r9_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (sp < SP_W'(DEPTH)));
    a_r9_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (sp != '0));
endmodule

// File: rtl/simd_issue.sv
`timescale 1ns/1ps
module simd_issue
    import simd_pkg::*;
#(
    parameter int N_LANES     = 8,
    parameter int CNT_W       = 8,
    parameter int STACK_DEPTH = 4,
    localparam int IMEM_DEPTH = 1 << PC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_addr,
    input  logic [15:0]        prog_data,
    input  logic               start,
    input  logic [N_LANES-1:0] pred_vec,
    output logic               bus_valid,
    output logic [15:0]        bus_instr,
    output logic [N_LANES-1:0] bus_mask,
    output logic               done
);
    logic [15:0]        imem [IMEM_DEPTH];
    seq_state_e         state, nxt_state;
    logic [PC_W-1:0]    pc, nxt_pc;
    logic [N_LANES-1:0] mask, nxt_mask;
    logic [CNT_W-1:0]   cnt, nxt_cnt;
    logic               push, pop, issue;
    instr_t             cur;
    logic [N_LANES-1:0] then_m, else_m;
    logic [N_LANES-1:0] top_saved, top_else;
    logic [PC_W-1:0]    top_join;

    always_ff @(posedge clk) begin
        if (prog_we) imem[prog_addr] <= prog_data;
    end

    assign cur    = instr_t'(imem[pc]);
    assign then_m = mask & pred_vec;
    assign else_m = mask & ~pred_vec;
    assign done   = (state == S_DONE);

    simd_mask_stack #(
        .N_LANES(N_LANES), .DEPTH(STACK_DEPTH), .PC_W(PC_W)
    ) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_saved(mask), .push_else(else_m), .push_join({cur.rb, cur.lo}),
        .top_saved(top_saved), .top_else(top_else), .top_join(top_join)
    );

    always_comb begin
        nxt_state = state;
        nxt_pc    = pc;
        nxt_mask  = mask;
        nxt_cnt   = cnt;
        push      = 1'b0;
        pop       = 1'b0;
        issue     = 1'b0;
        unique case (state)
            S_IDLE, S_DONE: begin
                if (start) begin
                    nxt_state = S_RUN;
                    nxt_pc    = '0;
                    nxt_mask  = '1;
                    nxt_cnt   = '0;
                end
            end
            S_RUN: begin
                if (is_lane_op(cur.op)) begin
                    issue  = 1'b1;
                    nxt_pc = PC_W'(pc + 1'b1);
                end else begin
                    case (cur.op)
                        OP_LOOP: begin
                            nxt_cnt = CNT_W'({cur.rb, cur.lo});
                            nxt_pc  = PC_W'(pc + 1'b1);
                        end
                        OP_ENDL: begin
                            if (cnt > CNT_W'(1)) begin
                                nxt_cnt = cnt - 1'b1;
                                nxt_pc  = {cur.rb, cur.lo};
                            end else begin
                                nxt_cnt = '0;
                                nxt_pc  = PC_W'(pc + 1'b1);
                            end
                        end
                        OP_IFP: nxt_state = S_SETTLE;
                        OP_ELS: begin
                            if (top_else != '0) begin
                                nxt_mask = top_else;
                                nxt_pc   = PC_W'(pc + 1'b1);
                            end else begin
                                nxt_pc = top_join;
                            end
                        end
                        OP_JOIN: begin
                            nxt_mask = top_saved;
                            pop      = 1'b1;
                            nxt_pc   = PC_W'(pc + 1'b1);
                        end
                        OP_HALT: nxt_state = S_DONE;
                        default: nxt_pc = PC_W'(pc + 1'b1);
                    endcase
                end
            end
            S_SETTLE: begin
                push      = 1'b1;
                nxt_state = S_RUN;
                if (then_m != '0) begin
                    nxt_mask = then_m;
                    nxt_pc   = PC_W'(pc + 1'b1);
                end else if (else_m != '0) begin
                    nxt_mask = else_m;
                    nxt_pc   = {cur.rd, cur.ra};
                end else begin
                    nxt_pc = {cur.rb, cur.lo};
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            pc    <= '0;
            mask  <= '0;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            pc    <= nxt_pc;
            mask  <= nxt_mask;
            cnt   <= nxt_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_valid <= 1'b0;
            bus_instr <= '0;
            bus_mask  <= '0;
        end else begin
            bus_valid <= issue;
            if (issue) begin
                bus_instr <= imem[pc];
                bus_mask  <= mask;
            end
        end
    end

    // R4: broadcasts only come out of the running state
    a_r4_bus_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> $past(state == S_RUN));
    // R4: halted machine waits for start
    a_r4_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && !start) |=> (state == S_DONE));
    // R3: sequencer-only words never reach the lanes
    a_r3_ctrl_not_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> is_lane_op(bus_instr[15:12]));
    // R6: no broadcast with an empty mask
    a_r6_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_mask != '0));
    // R5: a split only narrows the active set
    a_r5_split_narrows: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SETTLE) |=> ((mask & ~$past(mask)) == '0));
    // R5: join brings back the pre-branch mask from the stack
    a_r5_join_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && cur.op == OP_JOIN) |=> (mask == $past(top_saved)));
endmodule

// File: rtl/simd_array_top.sv
`timescale 1ns/1ps
module simd_array_top
    import simd_pkg::*;
#(
    parameter int N_LANES     = 8,
    parameter int DATA_W      = 16,
    parameter int MEM_DEPTH   = 32,
    parameter int STACK_DEPTH = 4,
    parameter int CNT_W       = 8,
    localparam int LANE_W     = $clog2(N_LANES),
    localparam int MEM_AW     = $clog2(MEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_addr,
    input  logic [15:0]        prog_data,
    input  logic               start,
    output logic               done,
    input  logic               host_we,
    input  logic [LANE_W-1:0]  host_lane,
    input  logic [MEM_AW-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               bus_valid,
    output logic [15:0]        bus_instr,
    output logic [N_LANES-1:0] bus_mask
);
    logic [N_LANES-1:0] pred_vec;
    logic [DATA_W-1:0]  lane_rd [N_LANES];

    simd_issue #(
        .N_LANES(N_LANES), .CNT_W(CNT_W), .STACK_DEPTH(STACK_DEPTH)
    ) u_issue (
        .clk(clk), .rst_n(rst_n),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .start(start), .pred_vec(pred_vec),
        .bus_valid(bus_valid), .bus_instr(bus_instr), .bus_mask(bus_mask),
        .done(done)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        simd_lane #(
            .DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH), .LANE_IDX(g)
        ) u_lane (
            .clk(clk), .rst_n(rst_n),
            .bus_valid(bus_valid), .bus_instr(bus_instr), .enable(bus_mask[g]),
            .host_we(host_we && (host_lane == LANE_W'(g))),
            .host_addr(host_addr), .host_wdata(host_wdata),
            .host_rdata(lane_rd[g]), .pred(pred_vec[g])
        );
    end

    assign host_rdata = lane_rd[host_lane];
endmodule

// File: tb/sim_simd_array_top.sv
`timescale 1ns/1ps
module sim_simd_array_top;
    import simd_pkg::*;
    localparam int N = 8, DW = 16, MD = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic prog_we = 0, start = 0, host_we = 0;
    logic [5:0] prog_addr = 0;
    logic [15:0] prog_data = 0;
    logic [2:0] host_lane = 0;
    logic [4:0] host_addr = 0;
    logic [DW-1:0] host_wdata = 0, host_rdata;
    logic done, bus_valid;
    logic [15:0] bus_instr;
    logic [N-1:0] bus_mask;

    simd_array_top #(.N_LANES(N), .DATA_W(DW), .MEM_DEPTH(MD)) u0 (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .start(start), .done(done), .host_we(host_we),
        .host_lane(host_lane), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .bus_valid(bus_valid), .bus_instr(bus_instr),
        .bus_mask(bus_mask));

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // encoders
    function automatic logic [15:0] w3(input logic [3:0] op, input int rd, input int ra, input int rb);
        return {op, 3'(rd), 3'(ra), 3'(rb), 3'b000};
    endfunction
    function automatic logic [15:0] wi(input logic [3:0] op, input int rd, input int imm);
        return {op, 3'(rd), 3'b000, 6'(imm)};
    endfunction
    function automatic logic [15:0] wb(input int et, input int jt);
        return {OP_IFP, 6'(et), 6'(jt)};
    endfunction

    logic [15:0] prog [64];
    int plen;

    // behavioural reference
    logic [DW-1:0] mreg [N][8];
    logic [DW-1:0] mmem [N][MD];
    bit            mpred [N];
    logic [15:0]   exp_i [$];
    logic [N-1:0]  exp_m [$];

    task automatic model_run();
        int pc = 0, cnt = 0, steps = 0;
        logic [N-1:0] mask = '1;
        logic [N-1:0] s_sav [$], s_els [$];
        int s_join [$];
        logic [15:0] w;
        logic [3:0] op;
        int rd, ra, rb, imm;
        logic [N-1:0] tm, em;
        while (steps < 20000) begin
            steps++;
            w = prog[pc]; op = w[15:12];
            rd = int'(w[11:9]); ra = int'(w[8:6]); rb = int'(w[5:3]); imm = int'(w[5:0]);
            if (op < 4'd9) begin
                exp_i.push_back(w); exp_m.push_back(mask);
                for (int l = 0; l < N; l++) if (mask[l]) begin
                    case (op)
                        4'd1: mreg[l][rd] = DW'(imm);
                        4'd2: mreg[l][rd] = mreg[l][ra] + mreg[l][rb];
                        4'd3: mreg[l][rd] = mreg[l][ra] - mreg[l][rb];
                        4'd4: mreg[l][rd] = mmem[l][mreg[l][ra][4:0]];
                        4'd5: mmem[l][mreg[l][ra][4:0]] = mreg[l][rb];
                        4'd6: mpred[l] = (mreg[l][ra] < mreg[l][rb]);
                        4'd8: mreg[l][rd] = DW'(l);
                        default: ;
                    endcase
                end
                pc++;
            end else if (op == 4'd9) begin cnt = imm; pc++; end
            else if (op == 4'd10) begin
                if (cnt > 1) begin cnt--; pc = imm; end else begin cnt = 0; pc++; end
            end else if (op == 4'd11) begin
                tm = '0; em = '0;
                for (int l = 0; l < N; l++) begin
                    tm[l] = mask[l] & mpred[l]; em[l] = mask[l] & ~mpred[l];
                end
                s_sav.push_back(mask); s_els.push_back(em); s_join.push_back(imm);
                if (tm != 0) begin mask = tm; pc++; end
                else if (em != 0) begin mask = em; pc = int'(w[11:6]); end
                else pc = imm;
            end else if (op == 4'd12) begin
                if (s_els[$] != 0) begin mask = s_els[$]; pc++; end else pc = s_join[$];
            end else if (op == 4'd13) begin
                mask = s_sav.pop_back(); void'(s_els.pop_back()); void'(s_join.pop_back()); pc++;
            end else if (op == 4'd15) break;
            else pc++;
        end
    endtask

    // bus monitor: compare every clock against the reference stream
    longint cyc = 0;
    always @(posedge clk) cyc++;
    bit mon_on = 0, after_done = 0;
    int nbcast = 0, n_ld = 0, n_st = 0, late = 0;
    longint bc_cyc [4];
    always @(negedge clk) begin
        if (after_done && bus_valid) late++;
        if (mon_on && bus_valid) begin
            if (nbcast < 4) bc_cyc[nbcast] = cyc;
            nbcast++;
            if (bus_instr[15:12] == 4'd4) n_ld++;
            if (bus_instr[15:12] == 4'd5) n_st++;
            if (exp_i.size() == 0) chk(0, "R2", "extra broadcast", bus_instr, 0);
            else begin
                logic [15:0] ei; logic [N-1:0] em;
                ei = exp_i.pop_front(); em = exp_m.pop_front();
                chk(bus_instr == ei, "R2", "broadcast word", bus_instr, ei);
                chk(bus_mask == em, "R5", "broadcast mask", bus_mask, em);
            end
        end
    end

    task automatic load_prog();
        for (int i = 0; i < plen; i++) begin
            @(negedge clk); prog_we = 1; prog_addr = 6'(i); prog_data = prog[i];
        end
        @(negedge clk); prog_we = 0;
    endtask

    task automatic hwr(input int l, input int a, input int d);
        @(negedge clk); host_we = 1; host_lane = 3'(l); host_addr = 5'(a); host_wdata = DW'(d);
        mmem[l][a] = DW'(d);
        @(negedge clk); host_we = 0;
    endtask

    task automatic hrd(input int l, input int a, output logic [DW-1:0] v);
        @(negedge clk); host_lane = 3'(l); host_addr = 5'(a);
        #1 v = host_rdata;
    endtask

    task automatic run_prog(output int expected_n);
        exp_i.delete(); exp_m.delete();
        model_run();
        expected_n = exp_i.size();
        nbcast = 0; n_ld = 0; n_st = 0; late = 0;
        mon_on = 1;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        begin
            int t = 0;
            while (!done && t < 3000) begin @(negedge clk); t++; end
            chk(done == 1'b1, "R4", "done reached", done, 1);
        end
        mon_on = 0; after_done = 1;
        repeat (6) @(negedge clk);
        chk(late == 0, "R4", "broadcasts after halt", late, 0);
        chk(done == 1'b1, "R4", "done held", done, 1);
        after_done = 0;
        chk(exp_i.size() == 0, "R2", "missing broadcasts", exp_i.size(), 0);
        chk(nbcast == expected_n, "R2", "issued count vs executed paths", nbcast, expected_n);
    endtask

    function automatic int av(input int l, input int k);
        case (k) 0: return l; 1: return l + 20; 2: return l; default: return (l * 5) % 8; endcase
    endfunction
    function automatic int bv(input int l, input int k);
        case (k) 0: return l + 10; 1: return l; 2: return 7 - l; default: return 3; endcase
    endfunction

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int en;
        logic [DW-1:0] v;
        for (int l = 0; l < N; l++) begin
            mpred[l] = 0;
            for (int r = 0; r < 8; r++) mreg[l][r] = '0;
            for (int a = 0; a < MD; a++) mmem[l][a] = 'x;
        end
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(bus_valid == 1'b0, "R1", "bus idle after reset", bus_valid, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && bus_valid == 1'b0, "R1", "idle before start", {done, bus_valid}, 0);

        // program 1: element-wise max, 4 iterations (R3, R5, R6, R7, R8)
        plen = 18;
        prog[0]  = wi(OP_LDI, 1, 0);
        prog[1]  = wi(OP_LDI, 2, 8);
        prog[2]  = wi(OP_LDI, 3, 16);
        prog[3]  = wi(OP_LDI, 4, 1);
        prog[4]  = wi(OP_LOOP, 0, 4);
        prog[5]  = w3(OP_LD, 5, 1, 0);
        prog[6]  = w3(OP_LD, 6, 2, 0);
        prog[7]  = w3(OP_SLT, 0, 5, 6);
        prog[8]  = wb(11, 12);
        prog[9]  = w3(OP_ST, 0, 3, 6);
        prog[10] = w3(OP_ELS, 0, 0, 0);
        prog[11] = w3(OP_ST, 0, 3, 5);
        prog[12] = w3(OP_JOIN, 0, 0, 0);
        prog[13] = w3(OP_ADD, 1, 1, 4);
        prog[14] = w3(OP_ADD, 2, 2, 4);
        prog[15] = w3(OP_ADD, 3, 3, 4);
        prog[16] = wi(OP_ENDL, 0, 5);
        prog[17] = w3(OP_HALT, 0, 0, 0);
        load_prog();
        for (int l = 0; l < N; l++)
            for (int k = 0; k < 4; k++) begin
                hwr(l, k, av(l, k)); hwr(l, 8 + k, bv(l, k)); hwr(l, 16 + k, 16'hDEAD);
            end
        run_prog(en);
        chk(bc_cyc[3] - bc_cyc[0] == 3, "R8", "four words in four clocks", bc_cyc[3] - bc_cyc[0], 3);
        chk(n_ld == 8, "R3", "loop body issued count times", n_ld, 8);
        chk(n_st == 6, "R6", "store broadcasts with skipped paths", n_st, 6);
        chk(en == 34, "R3", "reference broadcast total", en, 34);
        for (int l = 0; l < N; l++)
            for (int k = 0; k < 4; k++) begin
                int mx;
                mx = (av(l, k) > bv(l, k)) ? av(l, k) : bv(l, k);
                hrd(l, 16 + k, v);
                chk(v == DW'(mx), "R7", $sformatf("max lane %0d elem %0d", l, k), v, mx);
            end

        // program 2: nested branch on lane index (R9, R5, R2)
        plen = 19;
        prog[0]  = w3(OP_LID, 1, 0, 0);
        prog[1]  = wi(OP_LDI, 2, 2);
        prog[2]  = wi(OP_LDI, 3, 4);
        prog[3]  = wi(OP_LDI, 6, 31);
        prog[4]  = wi(OP_LDI, 7, 30);
        prog[5]  = w3(OP_SLT, 0, 1, 3);
        prog[6]  = wb(15, 16);
        prog[7]  = w3(OP_SLT, 0, 1, 2);
        prog[8]  = wb(12, 13);
        prog[9]  = wi(OP_LDI, 5, 1);
        prog[10] = w3(OP_ST, 0, 7, 5);
        prog[11] = w3(OP_ELS, 0, 0, 0);
        prog[12] = wi(OP_LDI, 5, 2);
        prog[13] = w3(OP_JOIN, 0, 0, 0);
        prog[14] = w3(OP_ELS, 0, 0, 0);
        prog[15] = wi(OP_LDI, 5, 3);
        prog[16] = w3(OP_JOIN, 0, 0, 0);
        prog[17] = w3(OP_ST, 0, 6, 5);
        prog[18] = w3(OP_HALT, 0, 0, 0);
        load_prog();
        for (int l = 0; l < N; l++) hwr(l, 30, 16'h00AA);
        run_prog(en);
        for (int l = 0; l < N; l++) begin
            int e31, e30;
            e31 = (l < 2) ? 1 : (l < 4) ? 2 : 3;
            e30 = (l < 2) ? 1 : 16'h00AA;
            hrd(l, 31, v);
            chk(v == DW'(e31), "R9", $sformatf("nested class lane %0d", l), v, e31);
            hrd(l, 30, v);
            chk(v == DW'(e30), "R2", $sformatf("masked lane untouched %0d", l), v, e30);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule